// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier with Low Switching Activity

This block multiplies two unsigned operands of `WIDTH` bits (32 by default) and returns the full double-width product. It works sequentially and retires one bit of the multiplier per clock. The work takes `WIDTH` cycles and needs only a single `WIDTH`-bit adder.

The datapath is arranged to keep flops and adder inputs still. The multiplier operand is never shifted. A one-hot ring of `WIDTH` flops picks the bit under test, and the same ring also serves as the iteration counter. The same hot position steers each finished product bit straight into its place in the low-half register, so that register never shifts either. The multiplicand feeds the adder with no gating in between. When the selected multiplier bit is zero, the addition is skipped and the upper partial product only realigns by one position.

A caller pulses `start` with the operands present and then waits for the one-cycle `done` pulse. From that pulse on, `product` holds the result until the next accepted start.

Top module: `lp_seq_mult`

## Requirements
- R1: After reset, `done` is 0 and `product` is all zeros.
- R2: For any operand pair, `product` equals the unsigned double-width product `a*b` when `done` is high.
- R3: If `start` is sampled high while the block is idle, `done` is high in the cycle after the `WIDTH`-th following clock edge. It is low in all cycles between, and it is high for exactly one cycle.
- R4: A `start` raised while an operation is running is ignored. The running operation keeps its original operands and its original `done` timing.
- R5: After `done`, `product` holds its value until the next accepted `start`.
- R6: Corner operands give exact results: any operand zero gives zero, both operands all ones give (2^WIDTH-1)^2, and single-bit operands give the matching single-bit product.
- R7: A `start` sampled in the cycle where `done` is high is accepted and begins a new operation.
- R8: The block works for any `WIDTH` of 2 or more, and the bypassing datapath variant (`SKIP_ZERO_ADD`=1) gives the same products as the always-adding variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; sampled only while idle |
| a | input | WIDTH | Multiplicand |
| b | input | WIDTH | Multiplier |
| product | output | 2*WIDTH | Product; upper half from the accumulator, lower half from the placed bits |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
The bench builds the default 32-bit instance with the bypassing datapath. It also builds a 3-bit instance with the always-adding datapath. The 3-bit instance can be driven through all 64 operand pairs, so every carry pattern and every ring position in that narrow case is covered. The 32-bit instance runs a table of corner and mixed operands. On it the bench also probes start-while-busy, start in the cycle of `done`, and product hold across idle cycles.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic {
      LPM_IDLE = 1'b0,
      LPM_RUN  = 1'b1
   } lpm_state_e;

endpackage

// File: rtl/lpm_ring.sv
module lpm_ring #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             home,
   input  logic             step,
   output logic [WIDTH-1:0] hot,
   output logic             at_last
);

   localparam logic [WIDTH-1:0] HOME_POS = {{(WIDTH-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (rst || home) hot <= HOME_POS;
      else if (step)   hot <= {hot[WIDTH-2:0], hot[WIDTH-1]};
   end

   assign at_last = hot[WIDTH-1];

   a_r3_ring_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot(hot));

endmodule

// File: rtl/lpm_upper.sv
module lpm_upper #(
   parameter int WIDTH         = 32,
   parameter bit SKIP_ZERO_ADD = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             en,
   input  logic             bit_sel,
   input  logic [WIDTH-1:0] mcand,
   output logic [WIDTH-1:0] acc,
   output logic             bit_out
);

   localparam int SUM_W = WIDTH + 1;

   logic [SUM_W-1:0] nxt;

   generate
      if (SKIP_ZERO_ADD) begin : g_bypass
         logic [SUM_W-1:0] add_res;
         assign add_res = {1'b0, acc} + {1'b0, mcand};
         assign nxt     = bit_sel ? add_res : {1'b0, acc};
      end else begin : g_plain
         assign nxt = {1'b0, acc} + {1'b0, mcand & {WIDTH{bit_sel}}};
      end
   endgenerate

   assign bit_out = nxt[0];

   always_ff @(posedge clk) begin
      if (rst || clr) acc <= '0;
      else if (en)    acc <= nxt[SUM_W-1:1];
   end

   a_r5_acc_idle: assert property (@(posedge clk) disable iff (rst)
      (!en && !clr) |=> $stable(acc));

endmodule

// File: rtl/lpm_lower.sv
module lpm_lower #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             en,
   input  logic [WIDTH-1:0] hot,
   input  logic             bit_in,
   output logic [WIDTH-1:0] lo
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst || clr)       lo[i] <= 1'b0;
         else if (en && hot[i]) lo[i] <= bit_in;
      end
   end

endmodule

// File: rtl/lp_seq_mult.sv
module lp_seq_mult #(
   parameter int WIDTH         = 32,
   parameter bit SKIP_ZERO_ADD = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   output logic [2*WIDTH-1:0] product,
   output logic               done
);
   import lpm_pkg::*;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("lp_seq_mult: WIDTH must be at least 2");
      end
   endgenerate

   lpm_state_e       state;
   logic             busy;
   logic             accept;
   logic [WIDTH-1:0] mcand_q;
   logic [WIDTH-1:0] mplier_q;
   logic [WIDTH-1:0] hot;
   logic             at_last;
   logic             bit_sel;
   logic             bit_new;
   logic [WIDTH-1:0] acc;
   logic [WIDTH-1:0] lo;

   assign busy    = (state == LPM_RUN);
   assign accept  = start && !busy;
   assign bit_sel = |(mplier_q & hot);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= LPM_IDLE;
         done     <= 1'b0;
         mcand_q  <= '0;
         mplier_q <= '0;
      end else begin
         done <= busy && at_last;
         if (accept) begin
            state    <= LPM_RUN;
            mcand_q  <= a;
            mplier_q <= b;
         end else if (busy && at_last) begin
            state <= LPM_IDLE;
         end
      end
   end

   lpm_ring #(.WIDTH(WIDTH)) u_ring (
      .clk(clk), .rst(rst), .home(accept), .step(busy),
      .hot(hot), .at_last(at_last)
   );

   lpm_upper #(.WIDTH(WIDTH), .SKIP_ZERO_ADD(SKIP_ZERO_ADD)) u_upper (
      .clk(clk), .rst(rst), .clr(accept), .en(busy), .bit_sel(bit_sel),
      .mcand(mcand_q), .acc(acc), .bit_out(bit_new)
   );

   lpm_lower #(.WIDTH(WIDTH)) u_lower (
      .clk(clk), .rst(rst), .clr(accept), .en(busy), .hot(hot),
      .bit_in(bit_new), .lo(lo)
   );

   assign product = {acc, lo};

   a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r3_done_idle: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   a_r4_busy_hold: assert property (@(posedge clk) disable iff (rst)
      (busy && start) |=> ($stable(mcand_q) && $stable(mplier_q)));
   a_r5_product_hold: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> $stable(product));

endmodule

// File: tb/lp_seq_mult_bench.sv
module lp_seq_mult_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 32;
   localparam int NW = 3;
   localparam int NVEC = 10;
   localparam logic [W-1:0] VA [NVEC] = '{
      32'h0000_0000, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000,
      32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0001_0000, 32'hAAAA_AAAA, 32'h0000_0007};
   localparam logic [W-1:0] VB [NVEC] = '{
      32'h9ABC_DEF0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000,
      32'h0000_0001, 32'hCAFE_F00D, 32'h0000_8000, 32'h5555_5555, 32'hFFFF_FFF9};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic [W-1:0]   a = '0, b = '0;
   logic [2*W-1:0] product;
   logic           done;
   logic n_start = 1'b0;
   logic [NW-1:0]   na = '0, nb = '0;
   logic [2*NW-1:0] n_product;
   logic            n_done;
   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lp_seq_mult #(.WIDTH(W), .SKIP_ZERO_ADD(1'b1)) u_lp_seq_mult (
      .clk(clk), .rst(rst), .start(start), .a(a), .b(b),
      .product(product), .done(done)
   );

   lp_seq_mult #(.WIDTH(NW), .SKIP_ZERO_ADD(1'b0)) u_lp_seq_mult_narrow (
      .clk(clk), .rst(rst), .start(n_start), .a(na), .b(nb),
      .product(n_product), .done(n_done)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one 32-bit operation; sample the done timing at every negedge.
   task automatic run32(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
      int early = 0;
      @(negedge clk); start = 1'b1; a = x; b = y;
      @(negedge clk); start = 1'b0; a = ~x; b = ~y;
      for (int c = 1; c <= W; c++) begin
         @(negedge clk);
         if (c < W && done) early++;
      end
      check("R3 no early done", 64'(early), 64'd0);
      check("R3 done at WIDTH cycles", {63'd0, done}, 64'd1);
      check(req, product, 64'(x) * 64'(y));
      @(negedge clk);
      check("R3 done single cycle", {63'd0, done}, 64'd0);
   endtask

   task automatic run_narrow(input logic [NW-1:0] x, input logic [NW-1:0] y);
      @(negedge n_start or negedge clk); n_start = 1'b1; na = x; nb = y;
      @(negedge clk); n_start = 1'b0;
      for (int c = 1; c <= NW; c++) @(negedge clk);
      check("R8 narrow product", {58'd0, n_product}, 64'(x) * 64'(y));
      check("R8 narrow done", {63'd0, n_done}, 64'd1);
   endtask

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 reset done", {63'd0, done}, 64'd0);
      check("R1 reset product", product, 64'd0);

      // R2 and R6: table walk (zeros, all ones, single bits, mixed)
      for (int i = 0; i < NVEC; i++) run32(VA[i], VB[i], "R2 R6 table product");

      // R5: product holds over idle cycles
      repeat (5) @(negedge clk);
      check("R5 product hold", product, 64'(VA[NVEC-1]) * 64'(VB[NVEC-1]));

      // R4: start while busy is ignored
      begin
         int early = 0;
         @(negedge clk); start = 1'b1; a = 32'h0000_0123; b = 32'h0000_0456;
         @(negedge clk); start = 1'b0;
         repeat (4) @(negedge clk);
         start = 1'b1; a = 32'hFFFF_0000; b = 32'h0F0F_0F0F;
         @(negedge clk); start = 1'b0;
         for (int c = 6; c <= W; c++) begin
            @(negedge clk);
            if (c < W && done) early++;
         end
         check("R4 timing unchanged", {63'd0, done}, 64'd1);
         check("R4 early done", 64'(early), 64'd0);
         check("R4 operands kept", product, 64'h123 * 64'h456);
      end

      // R7: start in the done cycle is accepted
      start = 1'b1; a = 32'h0000_0FFF; b = 32'h0001_0001;
      @(negedge clk); start = 1'b0;
      for (int c = 1; c <= W; c++) @(negedge clk);
      check("R7 back-to-back done", {63'd0, done}, 64'd1);
      check("R7 back-to-back product", product, 64'h0FFF * 64'h0001_0001);

      // R8: exhaustive narrow instance, always-adding variant
      for (int x = 0; x < 8; x++)
         for (int y = 0; y < 8; y++)
            run_narrow(NW'(x), NW'(y));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule